// File: doc/BRIEF.md
# Debug Memory Access Command Engine

This block carries out a single debugger memory-access command. A debugger first loads a small bank of data slots, writing the target address into slot 1 and, for a store, the value into slot 0. It then issues a command that carries a type code, an access size, a direction bit, an addressing-mode bit and a post-increment bit. The engine checks the command. It rejects modes it cannot perform and places one request on a simple memory port. When the response arrives, it returns read data into slot 0, zero-extended, and can advance the address in slot 1 by the access width in bytes.

Status has two parts. A busy flag shows that a request is in flight. A sticky three-bit error code records the first failure and holds it until the debugger clears it. Only physical addressing is implemented. The memory port can answer with a fault, and the engine reports that fault as an exception.

Top module: `dbg_memacc_engine`

## Requirements
- R1: A command with type code 2, accepted while not busy, raises `busy` and `mem_req` on the next cycle. At that point `mem_addr` holds the low ADDR_W bits of slot 1, `mem_we` holds the write bit and `mem_size` holds the size code. All of these stay unchanged until the cycle in which `mem_rsp_valid` is sampled high.
- R2: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. A code is supported only when it is at most 4 and its bit width is no more than DATA_W. With DATA_W=64, codes 4 to 7 are rejected.
- R3: On a read (write bit 0), the clock edge that samples the response ends the command. After that edge, `busy` and `mem_req` are 0 and slot 0 holds `mem_rdata` with every bit above the access width cleared.
- R4: On a write (write bit 1), `mem_wdata` equals slot 0 with every bit above the access width cleared, and slot 0 is left unchanged.
- R5: When a command completes without a fault and post-increment is set, slot 1 increases by the byte count of its size code. Without post-increment, slot 1 keeps its value.
- R6: A fault response (`mem_rsp_err`=1) ends the command with error code 3, and leaves slot 0 and slot 1 unchanged.
- R7: A command with type code other than 2, with the virtual bit set, or with an unsupported size sets error code 2. It issues no request and leaves `busy` at 0.
- R8: A command presented while busy sets error code 1 and is otherwise ignored: the request in flight keeps its address, size and direction. A fault in that same cycle takes priority and gives code 3.
- R9: The error code is sticky. A new error is recorded only while the code is 0, or in the cycle when `err_clr` is high. `err_clr` alone returns the code to 0 on the next cycle.
- R10: Slots 2 and up are never changed by a command. A debugger slot write (`slot_we`) lands on the next edge when not busy, and is dropped while busy.
- R11: After reset, `busy`, `mem_req`, `err_code` and all slots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_type | input | 8 | Command type code (2 = memory access) |
| cmd_size | input | 3 | Access size code |
| cmd_virtual | input | 1 | 1 = virtual addressing (not supported) |
| cmd_postinc | input | 1 | Advance the address slot after success |
| cmd_write | input | 1 | 1 = store slot 0, 0 = load into slot 0 |
| err_clr | input | 1 | Clear the sticky error code |
| slot_we | input | 1 | Debugger write strobe into the slot bank |
| slot_sel | input | $clog2(NUM_SLOTS) | Slot index for the debugger write |
| slot_wdata | input | DATA_W | Debugger write value |
| slots_flat | output | NUM_SLOTS*DATA_W | All slots, slot k at bits k*DATA_W upward |
| busy | output | 1 | A request is in flight |
| err_code | output | 3 | Sticky error: 0 none, 1 busy, 2 unsupported, 3 exception |
| mem_req | output | 1 | Memory request, held until response |
| mem_addr | output | ADDR_W | Request address |
| mem_we | output | 1 | Request is a store |
| mem_size | output | 3 | Request size code |
| mem_wdata | output | DATA_W | Store data, zero above access width |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rdata | input | DATA_W | Load data |
| mem_rsp_err | input | 1 | Response is a fault |

## Verification
Every result is registered once. Request signals and `busy` appear one edge after the accepting edge. A rejection or busy error shows in `err_code` one edge after the offending command. Slot updates, the end of `busy` and the fault code appear one edge after the response is sampled. The bench's reference model steps on the same rising edge, using only port values. Inputs are driven, and all outputs compared against the model, on the falling edge, so each result is checked in exactly the half-cycle in which it is due. A few literal checks after each scenario pin the error codes independently of the model.

// File: rtl/dbg_memacc_pkg.sv
package dbg_memacc_pkg;

   // Command type code that selects the memory access command
   localparam logic [7:0] CMDTYPE_MEM = 8'd2;

   // Largest size code defined for the command (16 bytes)
   localparam int unsigned MAX_SIZE_CODE = 4;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_BUSY  = 3'd1,
      ERR_UNSUP = 3'd2,
      ERR_EXC   = 3'd3
   } err_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } state_e;

   // Attributes of the access held while the request is in flight
   typedef struct packed {
      logic       we;
      logic       postinc;
      logic [2:0] size;
   } acc_s;

   function automatic int unsigned size_bits(int unsigned code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/dbg_memacc_mask.sv
module dbg_memacc_mask
   import dbg_memacc_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [2:0]        size,
   output logic [DATA_W-1:0] mask
);

   logic [DATA_W-1:0] tab [8];

   // One constant mask per size code; codes wider than the slot saturate
   for (genvar s = 0; s < 8; s++) begin : g_tab
      localparam int unsigned SB = size_bits(s);
      if (SB >= DATA_W) begin : g_full
         assign tab[s] = '1;
      end else begin : g_part
         assign tab[s] = {{(DATA_W-SB){1'b0}}, {SB{1'b1}}};
      end
   end

   assign mask = tab[size];

endmodule

// File: rtl/dbg_memacc_decode.sv
module dbg_memacc_decode
   import dbg_memacc_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [7:0]        cmd_type,
   input  logic [2:0]        cmd_size,
   input  logic              cmd_virtual,
   output logic              cmd_ok,
   output logic [DATA_W-1:0] cmd_mask
);

   logic [7:0] size_ok;

   // Size code is usable when defined and no wider than a data slot
   for (genvar s = 0; s < 8; s++) begin : g_size
      localparam bit FITS = (s <= MAX_SIZE_CODE) && (size_bits(s) <= DATA_W);
      assign size_ok[s] = FITS;
   end

   // Physical addressing only: any virtual request is refused
   assign cmd_ok = (cmd_type == CMDTYPE_MEM) && !cmd_virtual && size_ok[cmd_size];

   dbg_memacc_mask #(.DATA_W(DATA_W)) u_mask (
      .size (cmd_size),
      .mask (cmd_mask)
   );

endmodule

// File: rtl/dbg_memacc_bank.sv
module dbg_memacc_bank #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned NUM_SLOTS = 4,
   localparam int unsigned SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_we,
   input  logic [SEL_W-1:0]            host_sel,
   input  logic [DATA_W-1:0]           host_wdata,
   input  logic                        lock,
   input  logic                        a0_we,
   input  logic [DATA_W-1:0]           a0_d,
   input  logic                        a1_we,
   input  logic [DATA_W-1:0]           a1_d,
   output logic [NUM_SLOTS*DATA_W-1:0] slots_flat
);

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      logic              host_hit;
      logic [DATA_W-1:0] q;

      assign host_hit = host_we && !lock && (host_sel == SEL_W'(k));

      if (k == 0) begin : g_arg0
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (a0_we)    q <= a0_d;
            else if (host_hit) q <= host_wdata;
         end
      end else if (k == 1) begin : g_arg1
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (a1_we)    q <= a1_d;
            else if (host_hit) q <= host_wdata;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (host_hit) q <= host_wdata;
         end
      end

      assign slots_flat[k*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/dbg_memacc_seq.sv
module dbg_memacc_seq
   import dbg_memacc_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_ok,
   input  logic              cmd_write,
   input  logic              cmd_postinc,
   input  logic [2:0]        cmd_size,
   input  logic [DATA_W-1:0] cmd_mask,
   input  logic              err_clr,
   input  logic [DATA_W-1:0] arg0,
   input  logic [DATA_W-1:0] arg1,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rsp_err,
   output logic              busy,
   output logic [2:0]        err_code,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [2:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              a0_we,
   output logic [DATA_W-1:0] a0_d,
   output logic              a1_we,
   output logic [DATA_W-1:0] a1_d
);

   state_e            state_q;
   acc_s              acc_q;
   err_e              err_q;
   err_e              err_new;
   logic              accept;
   logic              done_ok;
   logic [DATA_W-1:0] held_mask;

   assign accept  = (state_q == ST_IDLE) && cmd_valid && cmd_ok;
   assign done_ok = (state_q == ST_WAIT) && mem_rsp_valid && !mem_rsp_err;

   // Error raised this cycle; a fault outranks a colliding busy command
   always_comb begin
      err_new = ERR_NONE;
      if (state_q == ST_WAIT) begin
         if (mem_rsp_valid && mem_rsp_err) err_new = ERR_EXC;
         else if (cmd_valid)               err_new = ERR_BUSY;
      end else if (cmd_valid && !cmd_ok) begin
         err_new = ERR_UNSUP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         acc_q     <= '0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (accept) begin
         state_q       <= ST_WAIT;
         acc_q.we      <= cmd_write;
         acc_q.postinc <= cmd_postinc;
         acc_q.size    <= cmd_size;
         mem_addr      <= arg1[ADDR_W-1:0];
         mem_wdata     <= arg0 & cmd_mask;
      end else if ((state_q == ST_WAIT) && mem_rsp_valid) begin
         state_q <= ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      err_q <= ERR_NONE;
      else if (err_clr)                err_q <= err_new;
      else if (err_q == ERR_NONE)      err_q <= err_new;
   end

   // Second lookup on the held size keeps the read path free of a mask register
   dbg_memacc_mask #(.DATA_W(DATA_W)) u_rmask (
      .size (acc_q.size),
      .mask (held_mask)
   );

   assign a0_we = done_ok && !acc_q.we;
   assign a0_d  = mem_rdata & held_mask;
   assign a1_we = done_ok && acc_q.postinc;
   assign a1_d  = arg1 + (DATA_W'(1) << acc_q.size);

   assign busy     = (state_q == ST_WAIT);
   assign mem_req  = (state_q == ST_WAIT);
   assign mem_we   = acc_q.we;
   assign mem_size = acc_q.size;
   assign err_code = err_q;

endmodule

// File: rtl/dbg_memacc_engine.sv
module dbg_memacc_engine #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_SLOTS = 4,
   localparam int unsigned SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [7:0]                  cmd_type,
   input  logic [2:0]                  cmd_size,
   input  logic                        cmd_virtual,
   input  logic                        cmd_postinc,
   input  logic                        cmd_write,
   input  logic                        err_clr,
   input  logic                        slot_we,
   input  logic [SEL_W-1:0]            slot_sel,
   input  logic [DATA_W-1:0]           slot_wdata,
   output logic [NUM_SLOTS*DATA_W-1:0] slots_flat,
   output logic                        busy,
   output logic [2:0]                  err_code,
   output logic                        mem_req,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic                        mem_we,
   output logic [2:0]                  mem_size,
   output logic [DATA_W-1:0]           mem_wdata,
   input  logic                        mem_rsp_valid,
   input  logic [DATA_W-1:0]           mem_rdata,
   input  logic                        mem_rsp_err
);

   if (!(DATA_W == 32 || DATA_W == 64 || DATA_W == 128)) begin : g_bad_data_w
      $error("DATA_W must be 32, 64 or 128");
   end
   if (ADDR_W > DATA_W || ADDR_W < 1) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..DATA_W");
   end
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 2");
   end

   logic              cmd_ok;
   logic [DATA_W-1:0] cmd_mask;
   logic              a0_we;
   logic              a1_we;
   logic [DATA_W-1:0] a0_d;
   logic [DATA_W-1:0] a1_d;
   logic [DATA_W-1:0] arg0;
   logic [DATA_W-1:0] arg1;

   assign arg0 = slots_flat[0      +: DATA_W];
   assign arg1 = slots_flat[DATA_W +: DATA_W];

   dbg_memacc_decode #(.DATA_W(DATA_W)) u_decode (
      .cmd_type    (cmd_type),
      .cmd_size    (cmd_size),
      .cmd_virtual (cmd_virtual),
      .cmd_ok      (cmd_ok),
      .cmd_mask    (cmd_mask)
   );

   dbg_memacc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_ok        (cmd_ok),
      .cmd_write     (cmd_write),
      .cmd_postinc   (cmd_postinc),
      .cmd_size      (cmd_size),
      .cmd_mask      (cmd_mask),
      .err_clr       (err_clr),
      .arg0          (arg0),
      .arg1          (arg1),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rdata     (mem_rdata),
      .mem_rsp_err   (mem_rsp_err),
      .busy          (busy),
      .err_code      (err_code),
      .mem_req       (mem_req),
      .mem_addr      (mem_addr),
      .mem_we        (mem_we),
      .mem_size      (mem_size),
      .mem_wdata     (mem_wdata),
      .a0_we         (a0_we),
      .a0_d          (a0_d),
      .a1_we         (a1_we),
      .a1_d          (a1_d)
   );

   dbg_memacc_bank #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (slot_we),
      .host_sel   (slot_sel),
      .host_wdata (slot_wdata),
      .lock       (busy),
      .a0_we      (a0_we),
      .a0_d       (a0_d),
      .a1_we      (a1_we),
      .a1_d       (a1_d),
      .slots_flat (slots_flat)
   );

endmodule

// File: rtl/dbg_memacc_chk.sv
module dbg_memacc_chk #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_SLOTS = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cmd_valid,
   input logic                        cmd_virtual,
   input logic                        err_clr,
   input logic                        busy,
   input logic [2:0]                  err_code,
   input logic                        mem_req,
   input logic [ADDR_W-1:0]           mem_addr,
   input logic                        mem_we,
   input logic [2:0]                  mem_size,
   input logic [DATA_W-1:0]           mem_wdata,
   input logic                        mem_rsp_valid,
   input logic                        mem_rsp_err,
   input logic [NUM_SLOTS*DATA_W-1:0] slots_flat
);

   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

   p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rsp_valid |=> !mem_req && !busy);

   p_byte_wdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && (mem_size == 3'd0) |-> (mem_wdata[DATA_W-1:8] == '0));

   p_store_keeps_arg0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_rsp_valid |=> $stable(slots_flat[DATA_W-1:0]));

   p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rsp_valid && mem_rsp_err && (err_code == 3'd0) && !err_clr |=> err_code == 3'd3);

   p_fault_keeps_slots_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_rsp_valid && mem_rsp_err |=> $stable(slots_flat));

   p_virtual_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && cmd_valid && cmd_virtual |=> !mem_req && !busy);

   p_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_valid && !mem_rsp_valid && (err_code == 3'd0) && !err_clr |=> (err_code == 3'd1) && busy);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) && !err_clr |=> $stable(err_code));

endmodule

bind dbg_memacc_engine dbg_memacc_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_SLOTS (NUM_SLOTS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_virtual   (cmd_virtual),
   .err_clr       (err_clr),
   .busy          (busy),
   .err_code      (err_code),
   .mem_req       (mem_req),
   .mem_addr      (mem_addr),
   .mem_we        (mem_we),
   .mem_size      (mem_size),
   .mem_wdata     (mem_wdata),
   .mem_rsp_valid (mem_rsp_valid),
   .mem_rsp_err   (mem_rsp_err),
   .slots_flat    (slots_flat)
);

// File: tb/dbg_memacc_engine_tb.sv
`timescale 1ns/1ps
module dbg_memacc_engine_tb;

   localparam int DW = 64;
   localparam int AW = 32;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_type = '0;
   logic [2:0]    cmd_size = '0;
   logic          cmd_virtual = 1'b0;
   logic          cmd_postinc = 1'b0;
   logic          cmd_write = 1'b0;
   logic          err_clr = 1'b0;
   logic          slot_we = 1'b0;
   logic [1:0]    slot_sel = '0;
   logic [DW-1:0] slot_wdata = '0;
   logic [NS*DW-1:0] slots_flat;
   logic          busy;
   logic [2:0]    err_code;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [2:0]    mem_size;
   logic [DW-1:0] mem_wdata;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_rsp_err = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;
   int latency  = 0;
   int lat_cnt  = 0;
   int cyc      = 0;
   bit cmp_en   = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dbg_memacc_engine #(.DATA_W(DW), .ADDR_W(AW), .NUM_SLOTS(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
      .cmd_size(cmd_size), .cmd_virtual(cmd_virtual), .cmd_postinc(cmd_postinc),
      .cmd_write(cmd_write), .err_clr(err_clr), .slot_we(slot_we),
      .slot_sel(slot_sel), .slot_wdata(slot_wdata), .slots_flat(slots_flat),
      .busy(busy), .err_code(err_code), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata), .mem_rsp_err(mem_rsp_err)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] width_mask(input logic [2:0] s);
      if (s >= 3'd3) return '1;
      return (64'd1 << (8 << s)) - 64'd1;
   endfunction

   // Reference model, stepped on the same edge as the design
   logic          m_busy, m_we, m_post;
   logic [AW-1:0] m_addr;
   logic [2:0]    m_size, m_err;
   logic [DW-1:0] m_wdata;
   logic [DW-1:0] m_slot [NS];

   always @(posedge clk) begin
      logic [2:0] code;
      logic       was_busy;
      if (!rst_n) begin
         m_busy = 0; m_we = 0; m_post = 0; m_addr = '0; m_size = '0;
         m_err = '0; m_wdata = '0;
         for (int k = 0; k < NS; k++) m_slot[k] = '0;
      end else begin
         code = 3'd0;
         was_busy = m_busy;
         if (m_busy) begin
            if (mem_rsp_valid && mem_rsp_err) code = 3'd3;
            else if (cmd_valid) code = 3'd1;
            if (mem_rsp_valid) begin
               if (!mem_rsp_err) begin
                  if (!m_we) m_slot[0] = mem_rdata & width_mask(m_size);
                  if (m_post) m_slot[1] = m_slot[1] + (64'd1 << m_size);
               end
               m_busy = 0;
            end
         end else if (cmd_valid) begin
            if (cmd_type != 8'd2 || cmd_virtual || cmd_size > 3'd3) code = 3'd2;
            else begin
               m_busy = 1; m_we = cmd_write; m_post = cmd_postinc; m_size = cmd_size;
               m_addr = m_slot[1][AW-1:0];
               m_wdata = m_slot[0] & width_mask(cmd_size);
            end
         end
         if (slot_we && !was_busy) m_slot[slot_sel] = slot_wdata;
         if (err_clr) m_err = code;
         else if (m_err == 3'd0) m_err = code;
      end
   end

   // Compare every output against the model on each falling edge
   always @(negedge clk) begin
      if (cmp_en) begin
         check("R1", "busy", DW'(busy), DW'(m_busy));
         check("R1", "mem_req", DW'(mem_req), DW'(m_busy));
         if (m_busy) begin
            check("R1", "mem_addr", DW'(mem_addr), DW'(m_addr));
            check("R1", "mem_we", DW'(mem_we), DW'(m_we));
            check("R2", "mem_size", DW'(mem_size), DW'(m_size));
            check("R4", "mem_wdata", mem_wdata, m_wdata);
         end
         check("R9", "err_code", DW'(err_code), DW'(m_err));
         check("R3", "slot0", slots_flat[0 +: DW], m_slot[0]);
         check("R5", "slot1", slots_flat[DW +: DW], m_slot[1]);
         for (int k = 2; k < NS; k++)
            check("R10", "upper slot", slots_flat[k*DW +: DW], m_slot[k]);
      end
   end

   // Memory responder: answers after 'latency' waiting cycles
   always @(negedge clk) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (mem_req && !mem_rsp_valid) begin
         if (lat_cnt >= latency) begin
            lat_cnt       <= 0;
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (mem_addr[11:8] == 4'hF);
            mem_rdata     <= {~mem_addr, mem_addr ^ 32'h5A5A_0000};
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
         finish_run();
      end
   end

   task automatic put_slot(input int k, input logic [DW-1:0] v);
      @(negedge clk);
      slot_we = 1'b1; slot_sel = 2'(k); slot_wdata = v;
      @(negedge clk);
      slot_we = 1'b0;
   endtask

   task automatic issue(input logic [7:0] t, input logic [2:0] s,
                        input logic v, input logic p, input logic w);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_type = t; cmd_size = s;
      cmd_virtual = v; cmd_postinc = p; cmd_write = w;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic clear_err();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check("R11", "busy after reset", DW'(busy), '0);
      check("R11", "mem_req after reset", DW'(mem_req), '0);
      check("R11", "err after reset", DW'(err_code), '0);
      check("R11", "slot0 after reset", slots_flat[0 +: DW], '0);
      cmp_en = 1'b1;

      // R10: debugger loads, including an upper slot
      put_slot(0, 64'hFEDC_BA98_7654_3210);
      put_slot(1, 64'h0000_0000_0000_1000);
      put_slot(2, 64'h1111_2222_3333_4444);

      // R1 R3: 32-bit read, no increment
      latency = 0;
      issue(8'd2, 3'd2, 1'b0, 1'b0, 1'b0); idle(4);
      // R3 R5: 64-bit read with increment, slower memory
      latency = 3;
      issue(8'd2, 3'd3, 1'b0, 1'b1, 1'b0); idle(8);
      // R4 R5: byte write with increment
      put_slot(0, 64'hAAAA_BBBB_CCCC_DDEE);
      latency = 1;
      issue(8'd2, 3'd0, 1'b0, 1'b1, 1'b1); idle(5);
      // R3: 16-bit read zero-extended
      issue(8'd2, 3'd1, 1'b0, 1'b0, 1'b0); idle(5);
      check("R3", "slot0 16-bit upper bits", slots_flat[16 +: 48], '0);

      // R2 R7: 16-byte size exceeds a 64-bit slot
      issue(8'd2, 3'd4, 1'b0, 1'b0, 1'b0); idle(2);
      check("R2", "err for size 4", DW'(err_code), 64'd2);
      clear_err(); idle(1);
      check("R9", "err after clear", DW'(err_code), '0);
      // R7: virtual addressing refused
      issue(8'd2, 3'd2, 1'b1, 1'b0, 1'b0); idle(2);
      check("R7", "err for virtual", DW'(err_code), 64'd2);
      clear_err();
      // R7: wrong command type
      issue(8'd0, 3'd2, 1'b0, 1'b0, 1'b0); idle(2);
      check("R7", "err for type 0", DW'(err_code), 64'd2);
      clear_err();

      // R6: faulting address, increment requested
      put_slot(1, 64'h0000_0000_0000_0F08);
      latency = 2;
      issue(8'd2, 3'd2, 1'b0, 1'b1, 1'b0); idle(6);
      check("R6", "err for fault", DW'(err_code), 64'd3);
      check("R6", "slot1 kept on fault", slots_flat[DW +: DW], 64'h0F08);
      // R9: later error does not overwrite
      issue(8'd2, 3'd7, 1'b0, 1'b0, 1'b0); idle(2);
      check("R9", "sticky code", DW'(err_code), 64'd3);
      clear_err();

      // R8 R10: command and slot write while busy
      put_slot(1, 64'h0000_0000_0000_2000);
      latency = 5;
      issue(8'd2, 3'd2, 1'b0, 1'b1, 1'b1);
      issue(8'd2, 3'd0, 1'b0, 1'b0, 1'b0);
      put_slot(2, 64'h9999_9999_9999_9999);
      idle(8);
      check("R8", "err for busy", DW'(err_code), 64'd1);
      check("R10", "slot2 write dropped while busy", slots_flat[2*DW +: DW], 64'h1111_2222_3333_4444);
      check("R5", "slot1 after 4-byte increment", slots_flat[DW +: DW], 64'h2004);
      clear_err(); idle(2);

      cmp_en = 1'b0;
      finish_run();
   end

endmodule